// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is an 8-bit timer-counter that advances once for every cycle in which its count-enable tick is high. A 3-bit mode field picks one of six counting schemes: plain free-running, clear-on-compare, fast PWM with a ceiling of 255 or of compare value A, and phase-correct (up/down) PWM with a ceiling of 255 or of compare value A. The same mode field also decides when the compare registers take new values and at which count the overflow flag is raised. Compare channel B drives one waveform pin. A 2-bit output-mode field selects what the pin does on a match, and whether it is enabled at all.

Software writes the control, compare and flag registers through a simple write port. It reads them back, and the live count, through a combinational read port. The counter direction is a two-state machine: `DIR_UP` and `DIR_DOWN`. Its transitions are **turn-down** (phase-correct, tick while counting up at the ceiling), **turn-up** (phase-correct, tick while counting down at zero) and **force-up** (any tick in a mode that is not phase-correct). The pin is a second two-state machine, `PIN_LOW` and `PIN_HIGH`. It moves on the events **set**, **clear** and **toggle**, which the mode, the output mode and the count direction select.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0, the direction is up, the overflow flag is 0, the pin is low, `wave_oe` and `wave_out` are 0, and every register reads 0.
- R2: Register addresses:
  - 0 is control: bits [2:0] are the mode, bits [5:4] are the output mode, and bits 7, 6 and 3 always read 0.
  - 1 is compare A and 2 is compare B; each reads back the last value written.
  - 3 holds the flag in bit 0, with the other bits reading 0.
  - 4 reads the count.
  - The count and direction hold in any cycle without a tick.
- R3: Modes 0, 4 and 6 count 0..255 and wrap to 0. Mode 2 returns to 0 on the tick after the count equals active compare A; a count above compare A runs on to 255 and wraps.
- R4: Fast PWM modes count up to the ceiling and return to 0 on the next tick. Mode 3 uses 255 as the ceiling and mode 7 uses active compare A.
- R5: Phase-correct modes count up to the ceiling, then down to 0, then up again, and each end value lasts exactly one tick. Mode 1 uses 255 as the ceiling and mode 5 uses active compare A.
- R6: A tick raises the overflow flag on the edge where the count leaves the flag point:
  - modes 0, 2, 4 and 6: the count leaves 255;
  - modes 3 and 7: the count leaves the ceiling;
  - modes 1 and 5: the count leaves 0 while counting down.

  The flag is sticky. Writing 1 to address 3 bit 0 clears it, writing 0 leaves it unchanged, and a set in the same cycle as a clear wins.
- R7: In modes 0, 2, 4 and 6, compare writes take effect at the same edge. In modes 1, 3, 5 and 7, the written values are copied to the active compare registers on the tick where the count leaves the ceiling.
- R8: In fast PWM, a tick leaving the ceiling sets the pin for output mode 2 and clears it for output mode 3. Otherwise a tick with the count equal to compare B clears the pin for output mode 2 and sets it for output mode 3. The ceiling action takes priority over the match.
- R9: In phase-correct PWM, a tick with the count equal to compare B does the following:
  - output mode 2: clears the pin while counting up and sets it while counting down;
  - output mode 3: does the opposite;
  - the match is ignored when compare B equals the ceiling.
- R10: In modes 0 and 2, a tick with the count equal to compare B toggles the pin for output mode 1, clears it for output mode 2 and sets it for output mode 3.
- R11: `wave_oe` is 1 only when all of these hold: the output mode is nonzero, the mode is not 4 or 6, and output mode 1 is not combined with a PWM mode. `wave_out` is 0 whenever `wave_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tick | input | 1 | Count enable, one step per high cycle |
| wave_out | output | 1 | Compare-B waveform pin |
| wave_oe | output | 1 | Waveform pin enable |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench sweeps every mode, every output mode and several compare-B values, including 0, the programmable ceiling and a value above it. This catches a phase-correct counter that dwells two ticks at an end value, and a pin that toggles when compare B sits on the ceiling. Compare values are rewritten in the middle of a period, so a design that applies them at once in a PWM mode shows a glitched duty cycle. A design that buffers them in plain modes lags by a period. The flag is raised in the same cycle as a clear, so a design that lets the clear win loses the event. Reserved modes and output mode 1 in PWM are swept, so a design that drives the pin in those cases shows a spurious enable.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL    = 3'd0,
        MD_PC_MAX    = 3'd1,
        MD_CTC       = 3'd2,
        MD_FAST_MAX  = 3'd3,
        MD_RSV_4     = 3'd4,
        MD_PC_CMPA   = 3'd5,
        MD_RSV_6     = 3'd6,
        MD_FAST_CMPA = 3'd7
    } tmr_mode_e;

    typedef enum logic [1:0] {
        WK_PLAIN,
        WK_FAST,
        WK_DUAL,
        WK_OFF
    } wave_kind_e;

    typedef enum logic [1:0] {
        FP_MAX,
        FP_TOP,
        FP_BOTTOM
    } flag_pt_e;

    typedef enum logic {
        DIR_UP,
        DIR_DOWN
    } dir_e;

    typedef enum logic {
        PIN_LOW,
        PIN_HIGH
    } pin_e;

    typedef struct packed {
        logic       top_is_cmpa;
        logic       reload_at_top;
        flag_pt_e   flag_pt;
        wave_kind_e kind;
    } mode_cfg_t;

    localparam int REG_CTRL = 0;
    localparam int REG_CMPA = 1;
    localparam int REG_CMPB = 2;
    localparam int REG_FLAG = 3;
    localparam int REG_CNT  = 4;

endpackage

// File: rtl/timer_mode_decode.sv
module timer_mode_decode
    import pwm_timer_pkg::*;
(
    input  tmr_mode_e mode,
    output mode_cfg_t cfg
);

    always_comb begin
        unique case (mode)
            MD_NORMAL:    cfg = '{top_is_cmpa: 1'b0, reload_at_top: 1'b0, flag_pt: FP_MAX,    kind: WK_PLAIN};
            MD_PC_MAX:    cfg = '{top_is_cmpa: 1'b0, reload_at_top: 1'b1, flag_pt: FP_BOTTOM, kind: WK_DUAL};
            MD_CTC:       cfg = '{top_is_cmpa: 1'b1, reload_at_top: 1'b0, flag_pt: FP_MAX,    kind: WK_PLAIN};
            MD_FAST_MAX:  cfg = '{top_is_cmpa: 1'b0, reload_at_top: 1'b1, flag_pt: FP_TOP,    kind: WK_FAST};
            MD_PC_CMPA:   cfg = '{top_is_cmpa: 1'b1, reload_at_top: 1'b1, flag_pt: FP_BOTTOM, kind: WK_DUAL};
            MD_FAST_CMPA: cfg = '{top_is_cmpa: 1'b1, reload_at_top: 1'b1, flag_pt: FP_TOP,    kind: WK_FAST};
            default:      cfg = '{top_is_cmpa: 1'b0, reload_at_top: 1'b0, flag_pt: FP_MAX,    kind: WK_OFF};
        endcase
    end

endmodule

// File: rtl/timer_counter.sv
module timer_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dual_slope,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    dir_e             dir_q, dir_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    // next state: force-up, turn-down, turn-up
    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        if (tick) begin
            if (!dual_slope) begin
                dir_d = DIR_UP;
                cnt_d = (cnt_q == top) ? ZERO : cnt_q + ONE;
            end else begin
                unique case (dir_q)
                    DIR_UP: begin
                        if (cnt_q >= top) begin
                            if (top != ZERO) begin
                                dir_d = DIR_DOWN;
                                cnt_d = top - ONE;
                            end
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end
                    DIR_DOWN: begin
                        if (cnt_q == ZERO) begin
                            if (top != ZERO) begin
                                dir_d = DIR_UP;
                                cnt_d = ONE;
                            end
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                endcase
            end
        end
    end

    assign cnt = cnt_q;
    assign dir = dir_q;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt_q) && $stable(dir_q))); // R2
    AST_UP_WHEN_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dual_slope) |=> (dir_q == DIR_UP)); // R3
    AST_DUAL_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dual_slope && top != ZERO && cnt_q <= top)
        |=> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE))); // R5

endmodule

// File: rtl/timer_wave.sv
module timer_wave
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wave_kind_e       kind,
    input  logic [1:0]       omode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] cmp_b,
    input  dir_e             dir,
    output logic             wave_out,
    output logic             wave_oe
);

    pin_e pin_q, pin_d;
    logic hit;

    assign hit = tick && (cnt == cmp_b);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= PIN_LOW;
        else        pin_q <= pin_d;
    end

    // next pin state: set, clear, toggle
    always_comb begin
        pin_d = pin_q;
        unique case (kind)
            WK_FAST: begin
                if (tick && omode[1]) begin
                    if (cnt == top)
                        pin_d = (omode == 2'd2) ? PIN_HIGH : PIN_LOW;
                    else if (cnt == cmp_b)
                        pin_d = (omode == 2'd2) ? PIN_LOW : PIN_HIGH;
                end
            end
            WK_DUAL: begin
                if (hit && omode[1] && (cmp_b != top)) begin
                    if ((dir == DIR_UP) == (omode == 2'd2)) pin_d = PIN_LOW;
                    else                                    pin_d = PIN_HIGH;
                end
            end
            WK_PLAIN: begin
                if (hit) begin
                    unique case (omode)
                        2'd1:    pin_d = (pin_q == PIN_HIGH) ? PIN_LOW : PIN_HIGH;
                        2'd2:    pin_d = PIN_LOW;
                        2'd3:    pin_d = PIN_HIGH;
                        default: pin_d = pin_q;
                    endcase
                end
            end
            default: pin_d = pin_q;
        endcase
    end

    // outputs
    always_comb begin
        wave_oe = (omode != 2'd0) && (kind != WK_OFF)
                  && !((omode == 2'd1) && (kind != WK_PLAIN));
        wave_out = wave_oe && (pin_q == PIN_HIGH);
    end

    AST_PIN_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin_q)); // R8
    AST_PIN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_OFF) |=> $stable(pin_q)); // R11
    AST_DUAL_TOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_DUAL && cmp_b == top && cnt == top) |=> $stable(pin_q)); // R9

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              tick,
    output logic              wave_out,
    output logic              wave_oe,
    output logic              ovf_flag
);

    localparam logic [CNT_W-1:0]  MAXV   = '1;
    localparam logic [CNT_W-1:0]  ZERO   = '0;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_CMPA = ADDR_W'(REG_CMPA);
    localparam logic [ADDR_W-1:0] A_CMPB = ADDR_W'(REG_CMPB);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(REG_FLAG);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);

    tmr_mode_e        mode_q;
    logic [1:0]       omode_q;
    logic [CNT_W-1:0] buf_a_q, buf_b_q, act_a_q, act_b_q;
    logic [CNT_W-1:0] nxt_buf_a, nxt_buf_b;
    logic             flag_q, flag_d, flag_evt, flag_clr;
    mode_cfg_t        cfg;
    logic [CNT_W-1:0] cnt, top;
    dir_e             dir;
    logic             reload_evt;
    logic [CNT_W-1:0] ctrl_rd;

    timer_mode_decode u_decode (
        .mode (mode_q),
        .cfg  (cfg)
    );

    assign top = cfg.top_is_cmpa ? act_a_q : MAXV;

    timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .dual_slope (cfg.kind == WK_DUAL),
        .top        (top),
        .cnt        (cnt),
        .dir        (dir)
    );

    timer_wave #(.CNT_W(CNT_W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .kind     (cfg.kind),
        .omode    (omode_q),
        .cnt      (cnt),
        .top      (top),
        .cmp_b    (act_b_q),
        .dir      (dir),
        .wave_out (wave_out),
        .wave_oe  (wave_oe)
    );

    always_comb begin
        nxt_buf_a  = (wr_en && wr_addr == A_CMPA) ? wr_data : buf_a_q;
        nxt_buf_b  = (wr_en && wr_addr == A_CMPB) ? wr_data : buf_b_q;
        reload_evt = tick && cfg.reload_at_top && (cnt == top);
        flag_clr   = wr_en && (wr_addr == A_FLAG) && wr_data[0];
        unique case (cfg.flag_pt)
            FP_TOP:    flag_evt = tick && (cnt == top);
            FP_BOTTOM: flag_evt = tick && (cnt == ZERO) && (dir == DIR_DOWN);
            default:   flag_evt = tick && (cnt == MAXV);
        endcase
        flag_d = flag_q;
        if (flag_clr) flag_d = 1'b0;
        if (flag_evt) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MD_NORMAL;
            omode_q <= 2'd0;
            buf_a_q <= ZERO;
            buf_b_q <= ZERO;
            act_a_q <= ZERO;
            act_b_q <= ZERO;
            flag_q  <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) begin
                mode_q  <= tmr_mode_e'(wr_data[2:0]);
                omode_q <= wr_data[5:4];
            end
            buf_a_q <= nxt_buf_a;
            buf_b_q <= nxt_buf_b;
            if (!cfg.reload_at_top || reload_evt) begin
                act_a_q <= nxt_buf_a;
                act_b_q <= nxt_buf_b;
            end
            flag_q <= flag_d;
        end
    end

    always_comb begin
        ctrl_rd      = ZERO;
        ctrl_rd[2:0] = mode_q;
        ctrl_rd[5:4] = omode_q;
        unique case (rd_addr)
            A_CTRL:  rd_data = ctrl_rd;
            A_CMPA:  rd_data = buf_a_q;
            A_CMPB:  rd_data = buf_b_q;
            A_FLAG:  rd_data = {{(CNT_W-1){1'b0}}, flag_q};
            A_CNT:   rd_data = cnt;
            default: rd_data = ZERO;
        endcase
    end

    assign ovf_flag = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q); // R6
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.reload_at_top && !reload_evt) |=> ($stable(act_a_q) && $stable(act_b_q))); // R7
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        flag_evt |=> flag_q); // R6

endmodule

// File: tb/tb_pwm_timer8.sv
`timescale 1ns/1ps
module tb_pwm_timer8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic       wave_out, wave_oe, ovf_flag;

    int vecs = 0;
    int errs = 0;

    // reference state
    logic [7:0] m_ctrl, m_bufa, m_bufb, m_acta, m_actb, m_cnt;
    logic       m_down, m_pin, m_flag;

    always #5 clk = ~clk;

    pwm_timer8 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .wave_out(wave_out), .wave_oe(wave_oe), .ovf_flag(ovf_flag)
    );

    initial begin
        #(1900000);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic m_is_dual();
        return (m_ctrl[2:0] == 3'd1) || (m_ctrl[2:0] == 3'd5);
    endfunction
    function automatic logic m_is_fast();
        return (m_ctrl[2:0] == 3'd3) || (m_ctrl[2:0] == 3'd7);
    endfunction
    function automatic logic [7:0] m_top();
        logic [2:0] md = m_ctrl[2:0];
        return (md == 3'd2 || md == 3'd5 || md == 3'd7) ? m_acta : 8'd255;
    endfunction
    function automatic logic m_oe();
        logic [1:0] om  = m_ctrl[5:4];
        logic       rsv = (m_ctrl[2:0] == 3'd4) || (m_ctrl[2:0] == 3'd6);
        return (om != 0) && !rsv && !(om == 1 && (m_is_dual() || m_is_fast()));
    endfunction

    task automatic m_reset();
        m_ctrl = 0; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0;
        m_cnt = 0; m_down = 0; m_pin = 0; m_flag = 0;
    endtask

    // one clock edge of the reference, using values from before the edge
    task automatic m_step(input logic tk, input logic we, input logic [2:0] a, input logic [7:0] d);
        logic [1:0] om   = m_ctrl[5:4];
        logic [2:0] md   = m_ctrl[2:0];
        logic       dual = m_is_dual();
        logic       fast = m_is_fast();
        logic       plain = (md == 3'd0) || (md == 3'd2);
        logic       lin  = !(dual || fast);
        logic [7:0] top  = m_top();
        logic [7:0] nba  = (we && a == 3'd1) ? d : m_bufa;
        logic [7:0] nbb  = (we && a == 3'd2) ? d : m_bufb;
        logic       ev   = 0;
        logic [7:0] ncnt = m_cnt;
        logic       ndown = m_down;
        logic       npin = m_pin;
        if (tk) begin
            if (dual)      ev = (m_cnt == 0) && m_down;
            else if (fast) ev = (m_cnt == top);
            else           ev = (m_cnt == 255);
            if (fast && om >= 2) begin
                if (m_cnt == top)       npin = (om == 2);
                else if (m_cnt == m_actb) npin = (om == 3);
            end else if (dual && om >= 2) begin
                if (m_cnt == m_actb && m_actb != top) npin = m_down ? (om == 2) : (om == 3);
            end else if (plain && m_cnt == m_actb) begin
                if (om == 1) npin = !m_pin;
                else if (om == 2) npin = 0;
                else if (om == 3) npin = 1;
            end
            if (!lin && m_cnt == top) begin m_acta = nba; m_actb = nbb; end
            if (dual) begin
                if (!m_down) begin
                    if (m_cnt < top) ncnt = m_cnt + 1;
                    else if (top != 0) begin ncnt = top - 1; ndown = 1; end
                end else begin
                    if (m_cnt != 0) ncnt = m_cnt - 1;
                    else if (top != 0) begin ncnt = 1; ndown = 0; end
                end
            end else begin
                ncnt = (m_cnt == top) ? 8'd0 : m_cnt + 8'd1;
                ndown = 0;
            end
        end
        if (lin) begin m_acta = nba; m_actb = nbb; end
        if (we && a == 3'd0) m_ctrl = d & 8'h37;
        if (we && a == 3'd3 && d[0]) m_flag = 0;
        if (ev) m_flag = 1;
        m_bufa = nba; m_bufb = nbb;
        m_cnt = ncnt; m_down = ndown; m_pin = npin;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(input logic tk, input logic we, input logic [2:0] a, input logic [7:0] d);
        tick = tk; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        m_step(tk, we, a, d);
        @(negedge clk);
        tick = 0; wr_en = 0;
    endtask

    task automatic cmp_all(input string ctag, input string wtag);
        rd_addr = 3'd4;
        #1;
        chk(ctag, rd_data, m_cnt);
        chk(wtag, wave_out, m_oe() && m_pin);
        chk("R11 oe", wave_oe, m_oe());
        chk("R6 flag", ovf_flag, m_flag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        tick = 0; wr_en = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        m_reset();
    endtask

    initial begin
        m_reset();
        do_reset();

        // R1 reset state
        for (int r = 0; r < 5; r++) begin
            rd_addr = 3'(r);
            #1;
            chk("R1 reg read", rd_data, 0);
        end
        chk("R1 oe", wave_oe, 0);
        chk("R1 wave", wave_out, 0);
        chk("R1 flag", ovf_flag, 0);

        // R2 readback with reserved bits
        cyc(0, 1, 3'd0, 8'hFF);
        rd_addr = 3'd0; #1; chk("R2 ctrl reserved zero", rd_data, 8'h37);
        cyc(0, 1, 3'd1, 8'h5A);
        rd_addr = 3'd1; #1; chk("R2 cmpa read", rd_data, 8'h5A);
        cyc(0, 1, 3'd2, 8'hC3);
        rd_addr = 3'd2; #1; chk("R2 cmpb read", rd_data, 8'hC3);
        rd_addr = 3'd3; #1; chk("R2 flag read", rd_data, 0);
        rd_addr = 3'd4; #1; chk("R2 count hold without tick", rd_data, 0);

        // sweep: all modes, all output modes, several compare B values
        for (int md = 0; md < 8; md++) begin
            for (int om = 0; om < 4; om++) begin
                for (int bi = 0; bi < 4; bi++) begin
                    logic [7:0] bv;
                    string ct, wt;
                    bv = (bi == 0) ? 8'd0 : (bi == 1) ? 8'd3 : (bi == 2) ? 8'd6 : 8'd200;
                    do_reset();
                    cyc(0, 1, 3'd1, 8'd6);
                    cyc(0, 1, 3'd2, bv);
                    cyc(0, 1, 3'd0, {2'b00, 2'(om), 1'b0, 3'(md)});
                    ct = m_is_dual() ? "R5 count" : m_is_fast() ? "R4 count" : "R3 count";
                    wt = m_is_dual() ? "R9 wave" : m_is_fast() ? "R8 wave" : "R10 wave";
                    for (int i = 0; i < 600; i++) begin
                        if (i == 300) begin
                            // R7 mid-period compare rewrite
                            cyc(0, 1, 3'd1, 8'd7);
                            cmp_all("R7 count", "R7 wave");
                            cyc(0, 1, 3'd2, bv + 8'd1);
                            cmp_all("R7 count", "R7 wave");
                        end
                        cyc((i % 7) != 3, 0, 3'd0, 8'd0);
                        cmp_all(ct, wt);
                    end
                end
            end
        end

        // R6 set beats clear, write zero keeps, write one clears
        do_reset();
        for (int i = 0; i < 255; i++) cyc(1, 0, 3'd0, 8'd0);
        rd_addr = 3'd4; #1; chk("R3 count at max", rd_data, 255);
        cyc(1, 1, 3'd3, 8'h01);
        chk("R6 set beats clear", ovf_flag, 1);
        cyc(0, 1, 3'd3, 8'h00);
        chk("R6 write zero keeps", ovf_flag, 1);
        rd_addr = 3'd3; #1; chk("R6 flag readback", rd_data, 1);
        cyc(0, 1, 3'd3, 8'h01);
        chk("R6 write one clears", ovf_flag, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule